// File: doc/BRIEF.md
# Programmable Almost-Empty / Almost-Full Flag Unit

This block sits beside the storage and pointer logic of a dual-clock FIFO and produces its two early-warning flags. Two threshold registers, one for each flag, hold the number of words at which the flag switches. Almost-empty is computed in the read-clock domain from the read pointer and a synchronized copy of the write pointer. Almost-full is computed in the write-clock domain from the write pointer and a synchronized copy of the read pointer. Pointers carry one wrap bit above the address bits.

The thresholds can be changed while the FIFO runs. Whether they are loaded one bit at a time from a serial input or a whole word at a time from the data bus is fixed at master reset by the level of the load-select line. The same level also picks the default threshold: a small one for parallel programming and a large one for serial programming. While load select is high, the write and read enables stop moving FIFO data. Instead they program the thresholds (write side) or return them on a readback bus (read side). A partial reset empties the FIFO pointers' effect on the flags and restarts the programming sequence, but keeps the thresholds and the programming method.

Top module: `pff_flag_unit`

## Requirements
- R1: On a write-clock edge with `mrst` high, the programming method becomes serial if `ld_sel` is 1 and parallel if it is 0. Both thresholds become `DEF_SER` (serial) or `DEF_PAR` (parallel).
- R2: In parallel mode, each write-clock edge with `wr_en` and `ld_sel` high and both resets low stores `din[AW-1:0]` into a threshold. Successive stores alternate, almost-empty first, then almost-full. Either reset points the sequence back at almost-empty.
- R3: In serial mode, each write-clock edge with `ser_en` and `ld_sel` high and both resets low stores `ser_in` into one threshold bit. The order is almost-empty bit 0 up to bit AW-1, then almost-full bit 0 up to bit AW-1. After 2*AW bits the order restarts at almost-empty bit 0, and either reset also restarts it there.
- R4: In parallel mode `ser_en` changes no threshold; in serial mode `wr_en` with `ld_sel` changes no threshold.
- R5: On a read-clock edge with `rd_en` and `ld_sel` high, `rb_data` takes a threshold, zero-extended. Successive reads alternate, almost-empty first, in either programming method. Either reset points the sequence back at almost-empty and clears `rb_data` to 0. Otherwise `rb_data` holds its value.
- R6: A partial reset (`prst` high, `mrst` low) leaves both thresholds and the programming method unchanged, and no threshold is written while it is high.
- R7: `almost_empty` is registered on the read clock. One edge after its inputs are applied it is 1 exactly when (`wptr_rsync` - `rptr`) modulo 2^(AW+1) is at or below the almost-empty threshold. It is 1 on every edge with a reset high.
- R8: `almost_full` is registered on the write clock. One edge after its inputs are applied it is 1 exactly when 2^AW minus (`wptr` - `rptr_wsync`) modulo 2^(AW+1) is at or below the almost-full threshold. It is 0 on every edge with a reset high.
- R9: `wr_go` equals `wr_en` and not `ld_sel`; `rd_go` equals `rd_en` and not `ld_sel`, combinationally.
- R10: The programming method changes only on edges with `mrst` high; `ld_sel` at other times does not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrst | input | 1 | Master reset, synchronous, active high |
| prst | input | 1 | Partial reset, synchronous, active high |
| ld_sel | input | 1 | Load select: routes enables to threshold programming and readback |
| ser_en | input | 1 | Serial shift enable |
| ser_in | input | 1 | Serial threshold bit |
| wr_en | input | 1 | Write enable |
| rd_en | input | 1 | Read enable |
| din | input | DW | Data bus, low AW bits used for parallel loads |
| wptr | input | AW+1 | Write pointer (write domain) |
| rptr_wsync | input | AW+1 | Read pointer synchronized into the write domain |
| rptr | input | AW+1 | Read pointer (read domain) |
| wptr_rsync | input | AW+1 | Write pointer synchronized into the read domain |
| almost_empty | output | 1 | Almost-empty flag, read domain |
| almost_full | output | 1 | Almost-full flag, write domain |
| rb_data | output | DW | Threshold readback |
| wr_go | output | 1 | Write enable qualified for the data path |
| rd_go | output | 1 | Read enable qualified for the data path |

## Verification
Threshold writes, readback words and both flags are registered, so each becomes visible one clock edge after the stimulus that causes it. The qualified enables `wr_go` and `rd_go` follow their inputs in the same cycle. The bench changes inputs on the falling edge. It checks registered results at the next falling edge, after exactly one rising edge. It checks the qualified enables a moment after driving them, before any rising edge. Flag sweeps cover every fill level from empty to full at shifted pointer bases, so the wrap bit is exercised, with thresholds taken from both defaults and from values programmed in each mode.

// File: rtl/pff_pkg.sv
package pff_pkg;

  typedef enum logic {
    PM_PARALLEL = 1'b0,
    PM_SERIAL   = 1'b1
  } prog_mode_e;

  typedef enum logic {
    TGT_AE = 1'b0,
    TGT_AF = 1'b1
  } off_tgt_e;

endpackage

// File: rtl/pff_offset_prog.sv
module pff_offset_prog
  import pff_pkg::*;
#(
  parameter int OW      = 16,
  parameter int DW      = 18,
  parameter int DEF_PAR = 127,
  parameter int DEF_SER = 1023
) (
  input  logic          wclk,
  input  logic          mrst,
  input  logic          prst,
  input  logic          ld_sel,
  input  logic          ser_en,
  input  logic          ser_in,
  input  logic          wr_en,
  input  logic [DW-1:0] din,
  output logic [OW-1:0] ae_off,
  output logic [OW-1:0] af_off
);

  localparam int CW = $clog2(2 * OW);
  localparam logic [CW-1:0] LAST_IDX = CW'(2 * OW - 1);
  localparam logic [CW-1:0] OW_C     = CW'(OW);
  localparam logic [OW-1:0] DEF_PAR_V = OW'(DEF_PAR);
  localparam logic [OW-1:0] DEF_SER_V = OW'(DEF_SER);

  prog_mode_e    mode;
  off_tgt_e      par_tgt;
  logic [CW-1:0] shift_cnt;

  // named events for the assertions
  logic          par_ld;
  logic          ser_ld;
  logic          ser_in_af;
  logic [CW-1:0] bit_idx;

  function automatic logic [OW-1:0] put_bit(input logic [OW-1:0] v,
                                            input logic [CW-1:0] idx,
                                            input logic          b);
    logic [OW-1:0] r;
    r = v;
    for (int k = 0; k < OW; k++) begin
      if (CW'(k) == idx) r[k] = b;
    end
    return r;
  endfunction

  always_comb begin
    par_ld    = (mode == PM_PARALLEL) && wr_en && ld_sel && !prst;
    ser_ld    = (mode == PM_SERIAL) && ser_en && ld_sel && !prst;
    ser_in_af = (shift_cnt >= OW_C);
    bit_idx   = ser_in_af ? (shift_cnt - OW_C) : shift_cnt;
  end

  always_ff @(posedge wclk) begin
    if (mrst) begin
      mode      <= ld_sel ? PM_SERIAL : PM_PARALLEL;
      ae_off    <= ld_sel ? DEF_SER_V : DEF_PAR_V;
      af_off    <= ld_sel ? DEF_SER_V : DEF_PAR_V;
      par_tgt   <= TGT_AE;
      shift_cnt <= '0;
    end else if (prst) begin
      par_tgt   <= TGT_AE;
      shift_cnt <= '0;
    end else begin
      if (par_ld) begin
        if (par_tgt == TGT_AE) ae_off <= din[OW-1:0];
        else                   af_off <= din[OW-1:0];
        par_tgt <= (par_tgt == TGT_AE) ? TGT_AF : TGT_AE;
      end
      if (ser_ld) begin
        if (ser_in_af) af_off <= put_bit(af_off, bit_idx, ser_in);
        else           ae_off <= put_bit(ae_off, bit_idx, ser_in);
        shift_cnt <= (shift_cnt == LAST_IDX) ? '0 : shift_cnt + 1'b1;
      end
    end
  end

  AST_PAR_TARGET_FLIPS: assert property (@(posedge wclk) disable iff (mrst || prst)
    par_ld |=> par_tgt != $past(par_tgt)); // R2

  AST_SHIFT_WRAPS: assert property (@(posedge wclk) disable iff (mrst || prst)
    (ser_ld && shift_cnt == LAST_IDX) |=> shift_cnt == '0); // R3

  AST_PRST_KEEPS_OFFSETS: assert property (@(posedge wclk) disable iff (mrst)
    prst |=> ($stable(ae_off) && $stable(af_off) && $stable(mode))); // R6

  AST_MODE_HELD: assert property (@(posedge wclk) disable iff (mrst)
    !mrst |=> $stable(mode)); // R10

endmodule

// File: rtl/pff_flag_cmp.sv
module pff_flag_cmp #(
  parameter int AW        = 16,
  parameter bit FULL_SIDE = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW:0]   head_ptr,
  input  logic [AW:0]   tail_ptr,
  input  logic [AW-1:0] off,
  output logic          flag
);

  localparam logic [AW:0] DEPTH_V = {1'b1, {AW{1'b0}}};

  function automatic logic [AW:0] fill_level(input logic [AW:0] head,
                                             input logic [AW:0] tail);
    return head - tail;
  endfunction

  function automatic logic [AW:0] room_left(input logic [AW:0] level);
    return DEPTH_V - level;
  endfunction

  logic [AW:0] level;
  logic [AW:0] room;
  logic [AW:0] off_ext;

  always_comb begin
    level   = fill_level(head_ptr, tail_ptr);
    room    = room_left(level);
    off_ext = {1'b0, off};
  end

  generate
    if (FULL_SIDE) begin : g_full
      always_ff @(posedge clk) begin
        if (rst) flag <= 1'b0;
        else     flag <= (room <= off_ext);
      end

      AST_AF_AT_FULL: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(room) == '0) |-> flag); // R8
    end else begin : g_empty
      always_ff @(posedge clk) begin
        if (rst) flag <= 1'b1;
        else     flag <= (level <= off_ext);
      end

      AST_AE_AT_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(level) == '0) |-> flag); // R7
    end
  endgenerate

endmodule

// File: rtl/pff_readback.sv
module pff_readback
  import pff_pkg::*;
#(
  parameter int OW = 16,
  parameter int DW = 18
) (
  input  logic          rclk,
  input  logic          rst,
  input  logic          ld_sel,
  input  logic          rd_en,
  input  logic [OW-1:0] ae_off,
  input  logic [OW-1:0] af_off,
  output logic [DW-1:0] rb_data
);

  off_tgt_e rb_tgt;
  logic     rb_go;

  assign rb_go = rd_en && ld_sel;

  always_ff @(posedge rclk) begin
    if (rst) begin
      rb_tgt  <= TGT_AE;
      rb_data <= '0;
    end else if (rb_go) begin
      rb_data <= (rb_tgt == TGT_AE) ? DW'(ae_off) : DW'(af_off);
      rb_tgt  <= (rb_tgt == TGT_AE) ? TGT_AF : TGT_AE;
    end
  end

  AST_RB_TARGET_FLIPS: assert property (@(posedge rclk) disable iff (rst)
    rb_go |=> rb_tgt != $past(rb_tgt)); // R5

  AST_RB_HOLDS: assert property (@(posedge rclk) disable iff (rst)
    !rb_go |=> $stable(rb_data)); // R5

endmodule

// File: rtl/pff_flag_unit.sv
module pff_flag_unit #(
  parameter int AW      = 16,
  parameter int DW      = 18,
  parameter int DEF_PAR = 127,
  parameter int DEF_SER = 1023
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrst,
  input  logic          prst,
  input  logic          ld_sel,
  input  logic          ser_en,
  input  logic          ser_in,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] din,
  input  logic [AW:0]   wptr,
  input  logic [AW:0]   rptr_wsync,
  input  logic [AW:0]   rptr,
  input  logic [AW:0]   wptr_rsync,
  output logic          almost_empty,
  output logic          almost_full,
  output logic [DW-1:0] rb_data,
  output logic          wr_go,
  output logic          rd_go
);

  logic [AW-1:0] ae_off;
  logic [AW-1:0] af_off;
  logic          any_rst;

  assign any_rst = mrst || prst;
  assign wr_go   = wr_en && !ld_sel;
  assign rd_go   = rd_en && !ld_sel;

  pff_offset_prog #(
    .OW(AW), .DW(DW), .DEF_PAR(DEF_PAR), .DEF_SER(DEF_SER)
  ) prog_i (
    .wclk(wclk), .mrst(mrst), .prst(prst), .ld_sel(ld_sel),
    .ser_en(ser_en), .ser_in(ser_in), .wr_en(wr_en), .din(din),
    .ae_off(ae_off), .af_off(af_off)
  );

  pff_readback #(.OW(AW), .DW(DW)) rb_i (
    .rclk(rclk), .rst(any_rst), .ld_sel(ld_sel), .rd_en(rd_en),
    .ae_off(ae_off), .af_off(af_off), .rb_data(rb_data)
  );

  pff_flag_cmp #(.AW(AW), .FULL_SIDE(1'b0)) ae_i (
    .clk(rclk), .rst(any_rst), .head_ptr(wptr_rsync), .tail_ptr(rptr),
    .off(ae_off), .flag(almost_empty)
  );

  pff_flag_cmp #(.AW(AW), .FULL_SIDE(1'b1)) af_i (
    .clk(wclk), .rst(any_rst), .head_ptr(wptr), .tail_ptr(rptr_wsync),
    .off(af_off), .flag(almost_full)
  );

  AST_LD_BLOCKS_DATA: assert property (@(posedge wclk) disable iff (mrst)
    ld_sel |-> (!wr_go && !rd_go)); // R9

endmodule

// File: tb/pff_flag_unit_tb_top.sv
module pff_flag_unit_tb_top;

  localparam int AW = 10;
  localparam int DW = 12;
  localparam int DEPTH = 1 << AW;
  localparam int PMOD = 2 << AW;

  logic clk = 1'b0;
  logic mrst, prst, ld_sel, ser_en, ser_in, wr_en, rd_en;
  logic [DW-1:0] din;
  logic [AW:0] wptr, rptr_wsync, rptr, wptr_rsync;
  logic almost_empty, almost_full, wr_go, rd_go;
  logic [DW-1:0] rb_data;

  int vectors = 0;
  int fails = 0;

  always #5 clk = ~clk;

  pff_flag_unit #(.AW(AW), .DW(DW), .DEF_PAR(127), .DEF_SER(1023)) dut_i (
    .wclk(clk), .rclk(clk), .mrst(mrst), .prst(prst), .ld_sel(ld_sel),
    .ser_en(ser_en), .ser_in(ser_in), .wr_en(wr_en), .rd_en(rd_en),
    .din(din), .wptr(wptr), .rptr_wsync(rptr_wsync), .rptr(rptr),
    .wptr_rsync(wptr_rsync), .almost_empty(almost_empty),
    .almost_full(almost_full), .rb_data(rb_data), .wr_go(wr_go), .rd_go(rd_go)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic set_occ(input int occ, input int base);
    rptr       = (AW+1)'(base % PMOD);
    wptr_rsync = (AW+1)'((base + occ) % PMOD);
    wptr       = (AW+1)'((base + occ) % PMOD);
    rptr_wsync = (AW+1)'(base % PMOD);
  endtask

  // flags one edge after the pointers are applied
  task automatic sweep(input int ae_t, input int af_t);
    for (int occ = 0; occ <= DEPTH; occ++) begin
      set_occ(occ, (occ * 37 + ae_t) % PMOD);
      tick();
      chk("R7 almost_empty", int'(almost_empty), (occ <= ae_t) ? 1 : 0);
      chk("R8 almost_full", int'(almost_full), ((DEPTH - occ) <= af_t) ? 1 : 0);
    end
  endtask

  task automatic read_pair(input string req, input int exp_ae, input int exp_af);
    ld_sel = 1'b1; rd_en = 1'b1;
    tick();
    chk({req, " readback ae"}, int'(rb_data), exp_ae);
    tick();
    chk({req, " readback af"}, int'(rb_data), exp_af);
    ld_sel = 1'b0; rd_en = 1'b0;
  endtask

  task automatic par_load(input int v);
    ld_sel = 1'b1; wr_en = 1'b1; din = DW'(v);
    tick();
    ld_sel = 1'b0; wr_en = 1'b0;
  endtask

  task automatic ser_shift(input int v, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      ld_sel = 1'b1; ser_en = 1'b1; ser_in = v[i];
      tick();
    end
    ld_sel = 1'b0; ser_en = 1'b0; ser_in = 1'b0;
  endtask

  task automatic master_reset(input logic sel);
    mrst = 1'b1; ld_sel = sel;
    repeat (3) tick();
    mrst = 1'b0; ld_sel = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    mrst = 1'b1; prst = 1'b0; ld_sel = 1'b0; ser_en = 1'b0; ser_in = 1'b0;
    wr_en = 1'b0; rd_en = 1'b0; din = '0;
    set_occ(0, 0);
    @(negedge clk);
    master_reset(1'b0);

    // R1 reset state, parallel defaults
    chk("R7 ae after reset", int'(almost_empty), 1);
    chk("R8 af after reset", int'(almost_full), 0);
    chk("R5 rb cleared", int'(rb_data), 0);
    read_pair("R1 parallel default", 127, 127);
    sweep(127, 127);

    // R2 parallel loads alternate
    par_load(300);
    par_load(900);
    read_pair("R2 parallel", 300, 900);
    sweep(300, 900);

    // R4 serial enable ignored in parallel mode
    ser_shift(32'h3FF, 5);
    read_pair("R4 ser_en ignored", 300, 900);

    // R9 qualified enables, no edge in between
    wr_en = 1'b1; rd_en = 1'b1; ld_sel = 1'b0; #1;
    chk("R9 wr_go open", int'(wr_go), 1);
    chk("R9 rd_go open", int'(rd_go), 1);
    ld_sel = 1'b1; #1;
    chk("R9 wr_go blocked", int'(wr_go), 0);
    chk("R9 rd_go blocked", int'(rd_go), 0);
    wr_en = 1'b0; rd_en = 1'b0; ld_sel = 1'b0; #1;
    chk("R9 wr_go idle", int'(wr_go), 0);
    @(negedge clk);

    // R6 partial reset
    par_load(55);
    set_occ(500, 11);
    prst = 1'b1; ld_sel = 1'b1; wr_en = 1'b1; din = DW'(77);
    tick();
    chk("R6 R7 ae during prst", int'(almost_empty), 1);
    chk("R6 R8 af during prst", int'(almost_full), 0);
    tick();
    prst = 1'b0; ld_sel = 1'b0; wr_en = 1'b0;
    read_pair("R6 offsets kept", 55, 900);
    par_load(66);
    read_pair("R6 R2 target back to ae", 66, 900);

    // R1 serial defaults
    master_reset(1'b1);
    read_pair("R1 serial default", 1023, 1023);
    sweep(1023, 1023);

    // R3 serial load, lsb first, ae then af
    ser_shift((675 << AW) | 341, 2 * AW);
    read_pair("R3 serial", 341, 675);

    // R4 R10 parallel write ignored, mode held in serial
    par_load(5);
    read_pair("R4 R10 wr_en ignored", 341, 675);

    // R3 count wraps to ae bit 0
    ser_shift(2, 3);
    read_pair("R3 wrap", 338, 675);
    sweep(338, 675);

    finish_run();
  end

endmodule